// File: doc/BRIEF.md
# Segmented Serial Shift Register with Sequenced Cell Strobes

This block is a 16-bit serial-in shift register. It is divided into four segments of four data cells. Each segment also has one spare temporary cell that sits after its last data cell. A storage cell is written only in a cycle in which its own write strobe is high. Every cell is kept on the system clock.

A one-cycle `shift_req` starts a sequencer. The sequencer raises five strobes, one per cycle, in reverse order:
1. The temporary-cell strobe.
2. The fourth data-cell strobe.
3. The third data-cell strobe.
4. The second data-cell strobe.
5. The first data-cell strobe.

Because of this order, every cell captures its upstream neighbour's old value before that neighbour is overwritten. The temporary cell carries a segment's outgoing bit into the next segment. All four segments share the same five strobes and update in parallel.

The result of a complete operation matches one clock of an ideal edge-triggered shift register. `busy` marks the sequence. `done` marks its completion. The parallel output shows all data cells in order from input to output. Software-free use is assumed: a producer holds `ser_in`, pulses `shift_req`, and waits for `done`.

Top module: `segshift_top`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears every data cell, every temporary cell and the sequencer. After that edge, `par_out` is 0, `ser_out` is 0, and `busy` and `done` are 0.
- R2: A `shift_req` sampled high while idle starts a sequence. `busy` is high for exactly K+1 = 5 consecutive cycles, starting the cycle after the request edge.
- R3: At most one of the five cell strobes is high in any cycle.
- R4: The temporary-cell strobe is the first strobe of a sequence. It copies the segment's fourth data cell into the temporary cell.
- R5: After the temporary-cell strobe, the data-cell strobes follow one per cycle from the fourth cell down to the first. Each of cells 2 to 4 takes the value of the cell before it.
- R6: The first data cell of segment 0 loads `ser_in` at the edge that ends the first-cell strobe. The first data cell of each later segment loads the temporary cell of the segment before it.
- R7: A `shift_req` that arrives while `busy` is high is ignored. The sequence length does not change, and the result is that of a single shift.
- R8: `done` is high for exactly one cycle, the cycle right after the first-cell strobe. `busy` is low in that cycle.
- R9: `par_out` bit j is data cell j counted from the input. Bit 0 is the first cell of segment 0, and bit 15 is the fourth cell of segment 3. `ser_out` equals bit 15. Temporary cells do not appear on any output.
- R10: When `done` is high, `par_out` equals `{old[14:0], ser_in}`. Here `old` is the `par_out` value before the request.
- R11: With no `shift_req`, `par_out`, `ser_out`, `busy` and `done` hold their values whatever `ser_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all cells and the sequencer update on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_req | input | 1 | One-cycle request to perform one shift; ignored while busy |
| ser_in | input | 1 | Serial data input, captured by the first-cell strobe |
| ser_out | output | 1 | Last data cell of the last segment |
| par_out | output | 16 | All data cells, bit 0 nearest the input |
| busy | output | 1 | High while the strobe sequence runs |
| done | output | 1 | One-cycle pulse after the sequence completes |

## Verification
Some properties are checked by assertions on every clock:
- At most one strobe is high in any cycle.
- A sequence always opens with the temporary-cell strobe.
- Each data-cell strobe is followed by the next lower one.
- Cells hold while no strobe is active.
- The temporary cells copy the fourth data cell.
- `done` follows the first-cell strobe and lasts one cycle.
- Reset clears the outputs.

Other properties can only be shown by the bench's scenarios:
- A complete sequence reproduces an ideal 16-bit shift, across random bit streams.
- A request made while busy leaves the result unchanged.
- Outputs hold through idle periods.
- `busy` lasts exactly five cycles.

// File: rtl/segshift_pkg.sv
// Package segshift_pkg
// Shared types for the segmented shift register. It assumes a single
// clock domain, in which one strobe lasts exactly one clock cycle.
package segshift_pkg;

    // Sequencer phase: idle, or issuing strobes
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/segshift_seq.sv
// Module segshift_seq
// Strobe sequencer. A request seen while idle starts K+1 strobes on
// consecutive cycles: the temporary-cell strobe strb[K] first, then the
// data-cell strobes strb[K-1] down to strb[0]. Requests that arrive during
// a sequence are ignored. done pulses for one cycle after strb[0].
// Assumes shift_req is synchronous to clk.
module segshift_seq
    import segshift_pkg::*;
#(
    parameter int K = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_req,
    output logic [K:0]   strb,
    output logic         busy,
    output logic         done
);

    localparam int CW = $clog2(K + 1);

    seq_state_e    state_q;
    logic [CW-1:0] step_q;
    logic          done_q;

    // Phase and step counter: load K on a request, count down to 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            step_q  <= '0;
        end else if (state_q == SEQ_IDLE) begin
            if (shift_req) begin
                state_q <= SEQ_RUN;
                step_q  <= CW'(K);
            end
        end else if (step_q == '0) begin
            state_q <= SEQ_IDLE;
        end else begin
            step_q <= step_q - 1'b1;
        end
    end

    // Completion pulse, registered one cycle after the last strobe
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (state_q == SEQ_RUN) && (step_q == '0);
    end

    // Strobe decode: one strobe per step value
    for (genvar i = 0; i <= K; i++) begin : g_strb
        assign strb[i] = (state_q == SEQ_RUN) && (step_q == CW'(i));
    end

    assign busy = (state_q == SEQ_RUN);
    assign done = done_q;

    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strb)); // R3
    AST_TEMP_STROBE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> strb[K]); // R4
    for (genvar i = 1; i <= K; i++) begin : g_ord
        AST_STROBE_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
            strb[i] |=> strb[i-1]); // R5
    end
    AST_DONE_AFTER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        strb[0] |=> (done && !busy)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

endmodule

// File: rtl/segshift_seg.sv
// Module segshift_seg
// One segment: K data cells and one temporary cell. Each cell loads only
// when its strobe is high. Assumes the strobes arrive one per cycle in
// reverse order, so every source still holds its old value when read.
module segshift_seg #(
    parameter int K = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [K:0]   strb,
    input  logic         seg_in,
    output logic [K-1:0] data,
    output logic         temp
);

    logic [K-1:0] data_q;
    logic         temp_q;

    // Data cells: cell 0 takes the segment input, cell i takes cell i-1
    for (genvar i = 0; i < K; i++) begin : g_cell
        if (i == 0) begin : g_head
            // First cell loads from the segment input
            always_ff @(posedge clk) begin
                if (!rst_n)       data_q[i] <= 1'b0;
                else if (strb[i]) data_q[i] <= seg_in;
            end
        end else begin : g_body
            // Later cells load from the upstream neighbour
            always_ff @(posedge clk) begin
                if (!rst_n)       data_q[i] <= 1'b0;
                else if (strb[i]) data_q[i] <= data_q[i-1];
            end
        end
    end

    // Temporary cell holds the outgoing bit for the next segment
    always_ff @(posedge clk) begin
        if (!rst_n)       temp_q <= 1'b0;
        else if (strb[K]) temp_q <= data_q[K-1];
    end

    assign data = data_q;
    assign temp = temp_q;

    AST_TEMP_COPIES_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        strb[K] |=> (temp == $past(data[K-1]))); // R4
    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (strb == '0) |=> ($stable(data) && $stable(temp))); // R11
    for (genvar i = 1; i < K; i++) begin : g_chk
        AST_CELL_FROM_PREV: assert property (@(posedge clk) disable iff (!rst_n)
            strb[i] |=> (data[i] == $past(data[i-1]))); // R5
    end
    AST_HEAD_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        strb[0] |=> (data[0] == $past(seg_in))); // R6

endmodule

// File: rtl/segshift_top.sv
// Module segshift_top
// Segmented serial shift register of W bits, built from W/K segments that
// share one strobe sequencer. Segment s takes its input from the temporary
// cell of segment s-1, and segment 0 takes ser_in. Assumes W is a multiple
// of K.
module segshift_top #(
    parameter int W = 16,
    parameter int K = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_req,
    input  logic         ser_in,
    output logic         ser_out,
    output logic [W-1:0] par_out,
    output logic         busy,
    output logic         done
);

    localparam int NSEG = W / K;

    logic [K:0]      strb;
    logic [NSEG-1:0] seg_temp;
    logic [NSEG-1:0] seg_in;

    segshift_seq #(.K(K)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_req (shift_req),
        .strb      (strb),
        .busy      (busy),
        .done      (done)
    );

    // Segment chain: each temporary cell feeds the next segment's head
    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        if (s == 0) begin : g_first
            assign seg_in[s] = ser_in;
        end else begin : g_next
            assign seg_in[s] = seg_temp[s-1];
        end

        segshift_seg #(.K(K)) u_seg (
            .clk    (clk),
            .rst_n  (rst_n),
            .strb   (strb),
            .seg_in (seg_in[s]),
            .data   (par_out[s*K +: K]),
            .temp   (seg_temp[s])
        );
    end

    assign ser_out = par_out[W-1];

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> ((par_out == '0) && !busy && !done)); // R1
    AST_LAST_TEMP_TRACKS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        strb[K] |=> (seg_temp[NSEG-1] == $past(ser_out))); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !shift_req) |=> $stable(par_out)); // R11

endmodule

// File: tb/segshift_top_bench.sv
// Bench for segshift_top: directed corner cases plus seeded random shifts,
// compared with an ideal 16-bit shift model held in the bench.
module segshift_top_bench;

    localparam int  W      = 16;
    localparam int  K      = 4;
    localparam time PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         shift_req = 1'b0;
    logic         ser_in = 1'b0;
    logic         ser_out;
    logic [W-1:0] par_out;
    logic         busy;
    logic         done;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] model = '0;

    segshift_top #(.W(W), .K(K)) u_segshift_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_req (shift_req),
        .ser_in    (ser_in),
        .ser_out   (ser_out),
        .par_out   (par_out),
        .busy      (busy),
        .done      (done)
    );

    always #(PERIOD/2) clk = ~clk;

    // Ideal shift reference
    function automatic logic [W-1:0] ideal_shift(logic [W-1:0] cur, logic b);
        return {cur[W-2:0], b};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One shift; optionally pulse an extra request while busy
    task automatic do_shift(input logic b, input bit extra);
        int bcnt = 0;
        @(negedge clk);
        ser_in    = b;
        shift_req = 1'b1;
        @(negedge clk);
        shift_req = 1'b0;
        while (busy && bcnt < 20) begin
            bcnt++;
            if (extra && bcnt == 2) shift_req = 1'b1;
            else                    shift_req = 1'b0;
            @(negedge clk);
        end
        shift_req = 1'b0;
        model = ideal_shift(model, b);
        chk(bcnt == K + 1, "R2 busy length", bcnt, K + 1);
        chk(done == 1'b1 && busy == 1'b0, "R8 done after sequence", {done, busy}, 2'b10);
        chk(par_out == model, "R10 shift result", par_out, model);
        chk(ser_out == model[W-1], "R9 serial output", ser_out, model[W-1]);
        @(negedge clk);
        chk(done == 1'b0, "R8 done single cycle", done, 0);
        chk(busy == 1'b0, "R7 no restart from ignored request", busy, 0);
    endtask

    // Watchdog
    initial begin
        #(PERIOD * 100000);
        fails++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] snap;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(par_out == '0 && !busy && !done, "R1 reset state", par_out, 0);

        // R6/R9: a single one walks from bit 0 to the serial output
        do_shift(1'b1, 1'b0);
        chk(par_out[0] == 1'b1, "R6 head loads serial input", par_out, 1);
        for (int i = 1; i < W; i++) do_shift(1'b0, 1'b0);
        chk(ser_out == 1'b1, "R9 bit reaches ser_out", ser_out, 1);
        // R6: bit crosses segment boundary via temporary cell (checked above by model)
        do_shift(1'b0, 1'b0);
        chk(par_out == '0, "R5 bit leaves register", par_out, 0);

        // R7: request during busy ignored
        do_shift(1'b1, 1'b1);
        do_shift(1'b1, 1'b1);

        // R11: idle hold while ser_in toggles
        snap = par_out;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            ser_in = ~ser_in;
        end
        @(negedge clk);
        chk(par_out == snap && !busy && !done, "R11 idle hold", par_out, snap);

        // Random streams against the ideal model
        for (int n = 0; n < 60; n++) begin
            do_shift(1'($urandom % 2), ($urandom % 4) == 0);
        end

        // All ones fill
        for (int n = 0; n < W; n++) do_shift(1'b1, 1'b0);
        chk(par_out == '1, "R10 all ones fill", par_out, 16'hffff);

        // R1: reset in the middle of a sequence
        @(negedge clk);
        shift_req = 1'b1;
        @(negedge clk);
        shift_req = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model = '0;
        chk(par_out == '0 && !busy && !done, "R1 reset during sequence",
            {par_out, busy, done}, 0);
        do_shift(1'b1, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule